// File: doc/BRIEF.md
# Stack and Direct-Page Effective Address Generator

This block forms the 24-bit effective address for one byte of a stack access, a stack-relative access or a direct-page operand access. Each cycle it takes the processor mode, the 16-bit stack pointer, the 16-bit direct register, an 8-bit operand offset, both index registers, the position of the byte within a multi-byte access and a code for the kind of access. It returns the address one clock later from a registered output stage. It does not decode instructions, time the bus or move data.

The two modes differ only in how the 16-bit sum is wrapped. In native mode every address is the 16-bit sum placed in bank 00. In the compatibility mode, ordinary stack and stack-relative accesses stay inside page one. Direct-page accesses wrap inside the page named by the direct high byte, but only when the direct low byte is zero. Two exempt access kinds are not wrapped in either mode: multi-byte stack transfers of long calls and returns, effective-address pushes and direct-register push/pull, and pointer fetches of the indirect-long direct modes. These carry across the page boundary instead.

Top module: `sdp_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `addr` becomes 0 at that edge.
- R2: `addr` is registered: it shows the result for the inputs sampled at the previous rising edge and does not change between edges.
- R3: With `emu` low, kinds 0 to 6 give bank 00 and a low 16 bits equal to the sum modulo 65536. For kinds 0 and 1 the sum is sp+seq. For kind 2 (stack-relative) it is sp+ofs+seq. For kinds 3, 4 and 5 (direct, direct+X, direct+Y) it is dreg+ofs+seq plus nothing, X or Y, with the full 16-bit index. For kind 6 (pointer fetch) it is dreg+ofs+seq.
- R4: With `emu` high, kinds 0 and 2 give 0x0001 in bits 23:8. Bits 7:0 are the low byte of sp+seq (kind 0) or of sp+ofs+seq (kind 2).
- R5: With `emu` high, kind 1 (exempt stack transfer) gives {0x00, (sp+seq) mod 65536} and may leave page one.
- R6: With `emu` high and dreg[7:0] equal to zero, kinds 3 to 5 give {0x00, dreg[15:8], low byte of ofs+index+seq}. This wraps inside one page and covers dreg equal to zero (page 0000).
- R7: With `emu` high and dreg[7:0] nonzero, kinds 3 to 5 give {0x00, (dreg+ofs+index+seq) mod 65536} with no page wrap.
- R8: With `emu` high, only bits 7:0 of `xidx` and `yidx` are used as the index. The high bytes have no effect on `addr`.
- R9: Kind 6 gives {0x00, (dreg+ofs+seq) mod 65536} in both modes. It uses no index, and a fetch starting at offset FE or FF carries into the next page.
- R10: Kind 7 is reserved and gives `addr` equal to 0.
- R11: `seq` is added before the mode wrap is applied, so in a wrapping case byte 1 or byte 2 of an access starting at FF or FE folds back to the bottom of the same page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| emu | input | 1 | 1 = compatibility mode, 0 = native mode |
| sp | input | 16 | Stack pointer |
| dreg | input | 16 | Direct register |
| ofs | input | 8 | Operand offset byte |
| xidx | input | 16 | X index value |
| yidx | input | 16 | Y index value |
| seq | input | 2 | Byte position within the access (0, 1, 2) |
| kind | input | 3 | Access kind code, 0 to 7 as listed in the requirements |
| addr | output | 24 | Registered effective address |

## Verification
Every mode and every kind code is swept against stack pointers that sit at the page-one edges and at the top of the bank, and against direct registers with a zero low byte, a nonzero low byte, both bytes zero and an all-ones high byte. This separates the page wrap from the plain 16-bit carry. Offsets 00, 01, 7F, FE and FF with byte positions 0 to 2 tell wrap-after-add apart from wrap-before-add and show the exempt kinds carrying across the boundary. Index values whose high byte is nonzero show that compatibility mode drops the high byte, while native mode carries the full index into the page number and across FFFF back to 0000.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [2:0] {
    K_STK      = 3'd0,
    K_STK_FREE = 3'd1,
    K_SREL     = 3'd2,
    K_DIR      = 3'd3,
    K_DIR_X    = 3'd4,
    K_DIR_Y    = 3'd5,
    K_DIR_PTR  = 3'd6,
    K_RSVD     = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    IX_NONE = 2'd0,
    IX_X    = 2'd1,
    IX_Y    = 2'd2
  } idx_sel_e;

  typedef struct packed {
    logic     stk;
    logic     free;
    logic     rel;
    logic     dir;
    logic     ptr;
    idx_sel_e isel;
    logic     zero;
  } ctl_t;

endpackage

// File: rtl/sdp_kind_dec.sv
module sdp_kind_dec
  import sdp_pkg::*;
(
  input  logic [2:0] kind,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '{stk: 1'b0, free: 1'b0, rel: 1'b0, dir: 1'b0,
            ptr: 1'b0, isel: IX_NONE, zero: 1'b0};
    unique case (kind_e'(kind))
      K_STK:      ctl.stk = 1'b1;
      K_STK_FREE: begin ctl.stk = 1'b1; ctl.free = 1'b1; end
      K_SREL:     begin ctl.stk = 1'b1; ctl.rel  = 1'b1; end
      K_DIR:      ctl.dir = 1'b1;
      K_DIR_X:    begin ctl.dir = 1'b1; ctl.isel = IX_X; end
      K_DIR_Y:    begin ctl.dir = 1'b1; ctl.isel = IX_Y; end
      K_DIR_PTR:  begin ctl.dir = 1'b1; ctl.ptr  = 1'b1; end
      default:    ctl.zero = 1'b1;
    endcase
  end

endmodule

// File: rtl/sdp_stack_gen.sv
module sdp_stack_gen #(
  parameter int AW = 24,
  parameter int RW = 16,
  parameter int OW = 8,
  parameter int SW = 2,
  parameter logic [RW/2-1:0] STK_PAGE = 'h01
) (
  input  logic          emu,
  input  logic          free,
  input  logic          rel,
  input  logic [RW-1:0] sp,
  input  logic [OW-1:0] ofs,
  input  logic [SW-1:0] seq,
  output logic [AW-1:0] addr
);

  localparam int PW = RW / 2;
  localparam int BW = AW - RW;

  logic [RW-1:0] ofs_ext;
  logic [RW-1:0] seq_ext;
  logic [RW-1:0] sum;
  logic          confine;

  assign ofs_ext = rel ? {{(RW-OW){1'b0}}, ofs} : '0;
  assign seq_ext = {{(RW-SW){1'b0}}, seq};
  assign sum     = sp + ofs_ext + seq_ext;
  assign confine = emu && !free;

  always_comb begin
    if (confine) addr = {{BW{1'b0}}, STK_PAGE, sum[PW-1:0]};
    else         addr = {{BW{1'b0}}, sum};
  end

endmodule

// File: rtl/sdp_direct_gen.sv
module sdp_direct_gen
  import sdp_pkg::*;
#(
  parameter int AW = 24,
  parameter int RW = 16,
  parameter int OW = 8,
  parameter int SW = 2
) (
  input  logic          emu,
  input  logic          ptr,
  input  idx_sel_e      isel,
  input  logic [RW-1:0] dreg,
  input  logic [OW-1:0] ofs,
  input  logic [RW-1:0] xidx,
  input  logic [RW-1:0] yidx,
  input  logic [SW-1:0] seq,
  output logic [AW-1:0] addr
);

  localparam int PW = RW / 2;
  localparam int BW = AW - RW;

  logic [RW-1:0] idx_raw;
  logic [RW-1:0] idx;
  logic [RW-1:0] pg;
  logic [RW-1:0] full;
  logic          wrap;

  always_comb begin
    unique case (isel)
      IX_X:    idx_raw = xidx;
      IX_Y:    idx_raw = yidx;
      default: idx_raw = '0;
    endcase
  end

  assign idx  = emu ? {{(RW-PW){1'b0}}, idx_raw[PW-1:0]} : idx_raw;
  assign pg   = {{(RW-OW){1'b0}}, ofs} + idx + {{(RW-SW){1'b0}}, seq};
  assign full = dreg + pg;
  assign wrap = emu && !ptr && (dreg[PW-1:0] == '0);

  always_comb begin
    if (wrap) addr = {{BW{1'b0}}, dreg[RW-1:PW], pg[PW-1:0]};
    else      addr = {{BW{1'b0}}, full};
  end

endmodule

// File: rtl/sdp_addr_gen.sv
module sdp_addr_gen
  import sdp_pkg::*;
#(
  parameter int AW = 24,
  parameter int RW = 16,
  parameter int OW = 8,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emu,
  input  logic [RW-1:0] sp,
  input  logic [RW-1:0] dreg,
  input  logic [OW-1:0] ofs,
  input  logic [RW-1:0] xidx,
  input  logic [RW-1:0] yidx,
  input  logic [SW-1:0] seq,
  input  logic [2:0]    kind,
  output logic [AW-1:0] addr
);

  ctl_t          ctl;
  logic [AW-1:0] stk_addr;
  logic [AW-1:0] dir_addr;
  logic [AW-1:0] nxt;
  logic [AW-1:0] addr_q;

  sdp_kind_dec u_dec (
    .kind (kind),
    .ctl  (ctl)
  );

  sdp_stack_gen #(.AW(AW), .RW(RW), .OW(OW), .SW(SW)) u_stk (
    .emu  (emu),
    .free (ctl.free),
    .rel  (ctl.rel),
    .sp   (sp),
    .ofs  (ofs),
    .seq  (seq),
    .addr (stk_addr)
  );

  sdp_direct_gen #(.AW(AW), .RW(RW), .OW(OW), .SW(SW)) u_dir (
    .emu  (emu),
    .ptr  (ctl.ptr),
    .isel (ctl.isel),
    .dreg (dreg),
    .ofs  (ofs),
    .xidx (xidx),
    .yidx (yidx),
    .seq  (seq),
    .addr (dir_addr)
  );

  always_comb begin
    if (ctl.stk)      nxt = stk_addr;
    else if (ctl.dir) nxt = dir_addr;
    else              nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= nxt;
  end

  assign addr = addr_q;

endmodule

// File: rtl/sdp_addr_chk.sv
module sdp_addr_chk #(
  parameter int AW = 24,
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          emu,
  input logic [RW-1:0] dreg,
  input logic [2:0]    kind,
  input logic [AW-1:0] addr
);

  localparam int PW = RW / 2;

  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (addr == '0));

  // R3
  native_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (!emu && kind != 3'd7) |=> (addr[AW-1:RW] == '0));

  // R4
  emu_stack_page_chk: assert property (@(posedge clk) disable iff (rst)
    (emu && (kind == 3'd0 || kind == 3'd2))
      |=> (addr[AW-1:PW] == {{(AW-RW){1'b0}}, {(PW-1){1'b0}}, 1'b1}));

  // R6
  emu_dp_page_chk: assert property (@(posedge clk) disable iff (rst)
    (emu && kind >= 3'd3 && kind <= 3'd5 && dreg[PW-1:0] == '0)
      |=> (addr[AW-1:PW] == {{(AW-RW){1'b0}}, $past(dreg[RW-1:PW])}));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == 3'd7) |=> (addr == '0));

endmodule

bind sdp_addr_gen sdp_addr_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .emu  (emu),
  .dreg (dreg),
  .kind (kind),
  .addr (addr)
);

// File: tb/sdp_addr_gen_test.sv
module sdp_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        emu = 1'b0;
  logic [15:0] sp = '0, dreg = '0, xidx = '0, yidx = '0;
  logic [7:0]  ofs = '0;
  logic [1:0]  seq = '0;
  logic [2:0]  kind = '0;
  logic [23:0] addr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sdp_addr_gen uut (
    .clk(clk), .rst(rst), .emu(emu), .sp(sp), .dreg(dreg), .ofs(ofs),
    .xidx(xidx), .yidx(yidx), .seq(seq), .kind(kind), .addr(addr)
  );

  function automatic int ref_addr(int m, int k, int s, int d, int o,
                                  int x, int y, int q);
    int ix;
    int t;
    ix = (k == 4) ? x : (k == 5) ? y : 0;
    if (m != 0) ix = ix % 256;
    case (k)
      0: return (m != 0) ? 256 + ((s + q) % 256) : (s + q) % 65536;
      1: return (s + q) % 65536;
      2: return (m != 0) ? 256 + ((s + o + q) % 256) : (s + o + q) % 65536;
      3, 4, 5: begin
        if (m != 0 && (d % 256) == 0) begin
          t = (o + ix + q) % 256;
          return (d / 256) * 256 + t;
        end
        return (d + o + ix + q) % 65536;
      end
      6: return (d + o + q) % 65536;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int m, int k, int d);
    if (k == 7) return "R10";
    if (k == 6) return "R9";
    if (m == 0) return "R3";
    if (k == 1) return "R5";
    if (k == 0 || k == 2) return "R4,R11";
    if ((d % 256) == 0) return "R6,R8,R11";
    return "R7,R8";
  endfunction

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: addr=%06h expected=%06h (emu=%0d kind=%0d sp=%04h d=%04h ofs=%02h x=%04h y=%04h seq=%0d)",
               tag, got, exp, emu, kind, sp, dreg, ofs, xidx, yidx, seq);
    end
  endtask

  initial begin
    int sps[4]  = '{16'h0100, 16'h01FF, 16'h12FE, 16'hFFFF};
    int ds[5]   = '{16'h0000, 16'h3400, 16'h0012, 16'hFF00, 16'h00FF};
    int ofv[5]  = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};
    int xs[3]   = '{16'h0000, 16'h0203, 16'hFFFE};
    int ys[3]   = '{16'h0001, 16'hAB80, 16'h00FF};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", addr, 0);
    @(negedge clk);
    emu = 1'b0; kind = 3'd1; sp = 16'h4321; seq = 2'd1;
    rst = 1'b0;
    // R2: nothing visible before the next edge
    #5 check("R2", addr, 0);
    @(negedge clk);
    check("R2", addr, 24'h004322);
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 8; k++)
        for (int si = 0; si < 4; si++)
          for (int di = 0; di < 5; di++)
            for (int oi = 0; oi < 5; oi++)
              for (int xi = 0; xi < 3; xi++)
                for (int q = 0; q < 3; q++) begin
                  emu = m[0]; kind = k[2:0]; sp = sps[si][15:0];
                  dreg = ds[di][15:0]; ofs = ofv[oi][7:0];
                  xidx = xs[xi][15:0]; yidx = ys[xi][15:0]; seq = q[1:0];
                  @(negedge clk);
                  check(req_of(m, k, ds[di]), addr,
                        ref_addr(m, k, sps[si], ds[di], ofv[oi],
                                 xs[xi], ys[xi], q));
                end
    // R8: high index bytes ignored in compatibility mode
    emu = 1'b1; kind = 3'd4; dreg = 16'h0500; ofs = 8'h10; seq = 2'd0;
    xidx = 16'h7720;
    @(negedge clk);
    check("R8", addr, 24'h000530);
    // R11: wrap applied after adding the byte position
    kind = 3'd3; ofs = 8'hFF; seq = 2'd2;
    @(negedge clk);
    check("R11", addr, 24'h000501);
    // R9: pointer fetch carries into the next page
    kind = 3'd6;
    @(negedge clk);
    check("R9", addr, 24'h000601);
    // R1: reset again clears the output
    rst = 1'b1;
    @(negedge clk);
    check("R1", addr, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule